// File: doc/BRIEF.md
# Per-Line Edge/Level Interrupt Request Latch

This block turns a bank of raw interrupt lines into a registered set of pending requests. At run time each line can be set to behave as level-sensitive or edge-sensitive. A level-sensitive line mirrors its input. An edge-sensitive line latches a request on a low-to-high transition and keeps it until an acknowledge removes it. The block stores each line's previous sampled level so that it can detect transitions inside one synchronous clock domain. Every input is sampled once per clock.

The trigger-mode byte is written and read through a simple port. A fixed, per-instance parameter sets which of its bits can ever be set. The primary controller of a cascaded pair uses the mask 0xF8, so lines 0 to 2 are always edge-sensitive. The secondary controller uses 0xDE. A controller re-initialisation strobe clears the pending and previous-level state and leaves the trigger-mode byte as it was. Prioritising, masking and raising the processor interrupt are done by the logic that reads `pend_o`.

Top module: `irq_req_latch`

## Requirements
- R1: For a line whose trigger-mode bit is 1 (level), both the pending bit and the previous-level bit equal the input sampled at the previous clock edge.
- R2: For a line whose trigger-mode bit is 0 (edge), the pending bit is set at a clock edge where the input is 1 and the previous-level bit is 0.
- R3: For an edge-mode line, an input that drops to 0 clears only the previous-level bit. An already latched pending bit stays set.
- R4: An edge-mode input that stays high after its request was acknowledged does not set the pending bit again until the input has gone low and then high.
- R5: When `ack_valid` is 1 and the line is in edge mode, the pending bit selected by `ack_line` (line index 0 to 7) is cleared. All other pending bits are unchanged.
- R6: An acknowledge of a level-mode line leaves its pending bit set while its input stays high.
- R7: A write stores `mode_wr_data & WR_MASK`, and `mode_rd` returns the stored value. Bits outside the mask always read 0. WR_MASK is 0xF8 for the primary instance and 0xDE for the secondary instance.
- R8: When `clr_state` is 1, the pending and previous-level registers are 0 after the edge. The trigger-mode byte keeps its value.
- R9: When `rst_n` is 0 at a clock edge, the pending, previous-level and trigger-mode registers are all 0 after that edge.
- R10: If a rising edge and an acknowledge hit the same edge-mode line in the same cycle, the new edge wins and the pending bit stays 1.
- R11: A trigger-mode write takes effect from the next clock edge. Sampling in the cycle of the write uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_state | input | 1 | Controller re-initialisation; clears pending and previous-level state |
| req_in | input | 8 | Raw interrupt request lines |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Index of the line being acknowledged |
| mode_wr_en | input | 1 | Trigger-mode write strobe |
| mode_wr_data | input | 8 | Trigger-mode write value (1 = level, 0 = edge) |
| mode_rd | output | 8 | Current trigger-mode byte |
| pend_o | output | 8 | Pending request register |
| prev_o | output | 8 | Previous sampled level per line |

## Verification
The two functions that can fall in the same cycle are an acknowledge and a fresh rising edge on the same edge-mode line. The bench raises line 0 again in exactly the cycle that acknowledges it and expects the pending bit to stay 1. In the next cycle it repeats the acknowledge with no new edge and expects the bit to clear. A second collision is also covered: a trigger-mode write in the same cycle as sampling. For that case the bench checks that the old mode governed that edge and the new mode governs the one after it.

// File: rtl/irq_latch_pkg.sv
// Shared constants for the interrupt request latch.
// Assumes a single synchronous clock domain for every user of the package.
package irq_latch_pkg;
    localparam int unsigned IRQ_LINES     = 8;
    localparam logic [7:0]  MASK_PRIMARY  = 8'hF8;
    localparam logic [7:0]  MASK_SECONDARY = 8'hDE;
endpackage

// File: rtl/irq_mode_reg.sv
// Trigger-mode register: one bit per line, 1 = level, 0 = edge.
// Only bits set in WR_MASK can ever hold a 1. The register is cleared by
// reset only, never by controller re-initialisation.
module irq_mode_reg #(
    parameter int unsigned      N_LINES = 8,
    parameter logic [N_LINES-1:0] WR_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_LINES-1:0] wr_data,
    output logic [N_LINES-1:0] mode_q
);
    // Store the write value filtered through the writable-bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_data & WR_MASK;
        end
    end
endmodule

// File: rtl/irq_ack_decode.sv
// Turns an acknowledge strobe plus a binary line index into a one-hot
// vector of per-line clear requests. Assumes N_LINES is a power of two.
module irq_ack_decode #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDX_W = $clog2(N_LINES)
) (
    input  logic               valid,
    input  logic [IDX_W-1:0]   line,
    output logic [N_LINES-1:0] hit
);
    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_dec
        // Assert the clear request for exactly the addressed line.
        assign hit[gi] = valid && (line == IDX_W'(gi));
    end
endmodule

// File: rtl/irq_line_cell.sv
// State for a single interrupt line: the pending bit and the last sampled
// level. In level mode both bits follow the input. In edge mode a 0->1
// transition sets the pending bit, which then holds until acknowledged.
// A new edge beats an acknowledge in the same cycle.
module irq_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic level_mode,
    input  logic din,
    input  logic ack_hit,
    output logic pend,
    output logic prev
);
    logic rise;

    // A rising edge is a high sample against a low stored level.
    assign rise = din && !prev;

    // Update the pending and previous-level bits once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend <= 1'b0;
            prev <= 1'b0;
        end else if (level_mode) begin
            pend <= din;
            prev <= din;
        end else begin
            prev <= din;
            pend <= rise || (pend && !ack_hit);
        end
    end
endmodule

// File: rtl/irq_req_latch.sv
// Top of the interrupt request latch. It holds the masked trigger-mode
// register, decodes the acknowledge, and has one line cell per request
// input. Assumes req_in is already synchronous to clk.
module irq_req_latch
    import irq_latch_pkg::*;
#(
    parameter int unsigned        N_LINES = IRQ_LINES,
    parameter logic [N_LINES-1:0] WR_MASK = MASK_PRIMARY,
    localparam int unsigned       IDX_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_state,
    input  logic [N_LINES-1:0] req_in,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_line,
    input  logic               mode_wr_en,
    input  logic [N_LINES-1:0] mode_wr_data,
    output logic [N_LINES-1:0] mode_rd,
    output logic [N_LINES-1:0] pend_o,
    output logic [N_LINES-1:0] prev_o
);
    logic [N_LINES-1:0] ack_hit;

    irq_mode_reg #(
        .N_LINES (N_LINES),
        .WR_MASK (WR_MASK)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode_q  (mode_rd)
    );

    irq_ack_decode #(
        .N_LINES (N_LINES)
    ) u_ack (
        .valid (ack_valid),
        .line  (ack_line),
        .hit   (ack_hit)
    );

    for (genvar gl = 0; gl < N_LINES; gl++) begin : g_line
        irq_line_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr_state),
            .level_mode (mode_rd[gl]),
            .din        (req_in[gl]),
            .ack_hit    (ack_hit[gl]),
            .pend       (pend_o[gl]),
            .prev       (prev_o[gl])
        );
    end
endmodule

// File: rtl/irq_req_latch_chk.sv
// Assertion checker for irq_req_latch, attached by bind. It observes
// the ports only.
module irq_req_latch_chk #(
    parameter int unsigned        N_LINES = 8,
    parameter logic [N_LINES-1:0] WR_MASK = '1,
    localparam int unsigned       IDX_W   = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_state,
    input logic [N_LINES-1:0] req_in,
    input logic               ack_valid,
    input logic [IDX_W-1:0]   ack_line,
    input logic               mode_wr_en,
    input logic [N_LINES-1:0] mode_wr_data,
    input logic [N_LINES-1:0] mode_rd,
    input logic [N_LINES-1:0] pend_o,
    input logic [N_LINES-1:0] prev_o
);
    a_r1_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_state |=> (((pend_o ^ $past(req_in)) | (prev_o ^ $past(req_in)))
                        & $past(mode_rd)) == '0);

    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_state |=> (($past(req_in) & ~$past(prev_o)) & ~pend_o) == '0);

    a_r3_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_state && !ack_valid) |=>
            ($past(pend_o) & ~$past(mode_rd) & ~pend_o) == '0);

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_state && ack_valid && !mode_rd[ack_line]
         && !(req_in[ack_line] && !prev_o[ack_line])) |=> !pend_o[$past(ack_line)]);

    a_r6_level_ack_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_state && ack_valid && mode_rd[ack_line] && req_in[ack_line])
            |=> pend_o[$past(ack_line)]);

    a_r7_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> mode_rd == ($past(mode_wr_data) & WR_MASK));

    a_r8_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr_state |=> (pend_o == '0) && (prev_o == '0));

    a_r8_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_state && !mode_wr_en) |=> $stable(mode_rd));

    a_r10_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_state && ack_valid && !mode_rd[ack_line]
         && req_in[ack_line] && !prev_o[ack_line]) |=> pend_o[$past(ack_line)]);
endmodule

bind irq_req_latch irq_req_latch_chk #(
    .N_LINES (N_LINES),
    .WR_MASK (WR_MASK)
) u_chk (.*);

// File: tb/tb_irq_req_latch.sv
// Self-checking bench: a vector table walked by one loop, then directed
// checks for reset and the secondary-controller mask.
module tb_irq_req_latch;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       clr_state;
    logic [7:0] req_in;
    logic       ack_valid;
    logic [2:0] ack_line;
    logic       mode_wr_en;
    logic [7:0] mode_wr_data;
    logic [7:0] mode_rd, pend_o, prev_o;
    logic [7:0] mode_rd2, pend2, prev2;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_req_latch #(.WR_MASK(8'hF8)) dut (
        .clk(clk), .rst_n(rst_n), .clr_state(clr_state), .req_in(req_in),
        .ack_valid(ack_valid), .ack_line(ack_line), .mode_wr_en(mode_wr_en),
        .mode_wr_data(mode_wr_data), .mode_rd(mode_rd), .pend_o(pend_o),
        .prev_o(prev_o)
    );

    irq_req_latch #(.WR_MASK(8'hDE)) dut_sec (
        .clk(clk), .rst_n(rst_n), .clr_state(clr_state), .req_in(req_in),
        .ack_valid(ack_valid), .ack_line(ack_line), .mode_wr_en(mode_wr_en),
        .mode_wr_data(mode_wr_data), .mode_rd(mode_rd2), .pend_o(pend2),
        .prev_o(prev2)
    );

    typedef struct packed {
        logic       clr;
        logic       ackv;
        logic [2:0] ackl;
        logic       wr;
        logic [7:0] wd;
        logic [7:0] req;
        logic [7:0] ep;
        logic [7:0] epv;
        logic [7:0] em;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,3'd0,1'b1,8'hFF,8'h00,8'h00,8'h00,8'hF8}, // R7 primary mask
        '{1'b0,1'b0,3'd0,1'b0,8'h00,8'h81,8'h81,8'h81,8'hF8}, // R1/R2
        '{1'b0,1'b0,3'd0,1'b0,8'h00,8'h01,8'h01,8'h01,8'hF8}, // R1 level drop
        '{1'b0,1'b0,3'd0,1'b0,8'h00,8'h00,8'h01,8'h00,8'hF8}, // R3
        '{1'b0,1'b1,3'd0,1'b0,8'h00,8'h01,8'h01,8'h01,8'hF8}, // R10
        '{1'b0,1'b1,3'd0,1'b0,8'h00,8'h01,8'h00,8'h01,8'hF8}, // R5
        '{1'b0,1'b0,3'd0,1'b0,8'h00,8'h01,8'h00,8'h01,8'hF8}, // R4
        '{1'b0,1'b0,3'd0,1'b0,8'h00,8'h12,8'h12,8'h12,8'hF8}, // R2
        '{1'b0,1'b1,3'd4,1'b0,8'h00,8'h12,8'h12,8'h12,8'hF8}, // R6
        '{1'b0,1'b1,3'd1,1'b0,8'h00,8'h12,8'h10,8'h12,8'hF8}, // R5
        '{1'b0,1'b0,3'd0,1'b1,8'h00,8'h12,8'h10,8'h12,8'h00}, // R11
        '{1'b0,1'b0,3'd0,1'b0,8'h00,8'h02,8'h10,8'h02,8'h00}, // R11
        '{1'b1,1'b0,3'd0,1'b0,8'h00,8'h02,8'h00,8'h00,8'h00}, // R8
        '{1'b0,1'b0,3'd0,1'b1,8'h07,8'h02,8'h02,8'h02,8'h00}, // R7
        '{1'b0,1'b0,3'd0,1'b1,8'h5A,8'h00,8'h02,8'h00,8'h58}, // R7
        '{1'b1,1'b0,3'd0,1'b0,8'h00,8'h08,8'h00,8'h00,8'h58}, // R8
        '{1'b0,1'b0,3'd0,1'b0,8'h00,8'h08,8'h08,8'h08,8'h58}  // R1
    };

    function automatic string row_tag(int i);
        case (i)
            0, 13, 14: return "R7";
            1, 2, 16:  return "R1";
            3:         return "R3";
            4:         return "R10";
            5, 9:      return "R5";
            6:         return "R4";
            7:         return "R2";
            8:         return "R6";
            10, 11:    return "R11";
            default:   return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        clr_state = 1'b0; req_in = 8'h00; ack_valid = 1'b0; ack_line = 3'd0;
        mode_wr_en = 1'b0; mode_wr_data = 8'h00;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9", "pend", pend_o, 8'h00);
        check("R9", "prev", prev_o, 8'h00);
        check("R9", "mode", mode_rd, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            clr_state    = VEC[i].clr;
            ack_valid    = VEC[i].ackv;
            ack_line     = VEC[i].ackl;
            mode_wr_en   = VEC[i].wr;
            mode_wr_data = VEC[i].wd;
            req_in       = VEC[i].req;
            @(posedge clk);
            #1;
            check(row_tag(i), "pend", pend_o, VEC[i].ep);
            check(row_tag(i), "prev", prev_o, VEC[i].epv);
            check(row_tag(i), "mode", mode_rd, VEC[i].em);
        end

        // R7: secondary instance mask 0xDE
        @(negedge clk);
        idle_inputs();
        mode_wr_en = 1'b1; mode_wr_data = 8'hFF;
        @(posedge clk);
        #1;
        check("R7", "secondary mode", mode_rd2, 8'hDE);

        // R9: reset in mid-run clears everything including trigger mode
        @(negedge clk);
        idle_inputs();
        req_in = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9", "pend after reset", pend_o, 8'h00);
        check("R9", "prev after reset", prev_o, 8'h00);
        check("R9", "mode after reset", mode_rd, 8'h00);
        check("R9", "secondary mode after reset", mode_rd2, 8'h00);

        // R2: after release all lines are edge mode and rise together
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R2", "all-edge rise", pend_o, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule